// File: doc/BRIEF.md
# Runaway Watchdog With Mode-Driven Clearing

This block catches a processor that has stopped running its normal program. A free-running counter, clocked by the oscillator, starts on its own once power-on reset is released. Firmware has to restart it from zero at regular intervals by writing 0 to a clear bit. If the counter reaches its last value without such a write, the block drives an internal reset pulse of a fixed length.

Besides the software clear, several system conditions zero the counter. These are a stopped main oscillator and entry into the low-power sleep, timebase-timer or watch modes. While any of these conditions stays asserted, the counter stays at zero. In stop mode the processor is halted, so the counter freezes at its current value and is not cleared. During its own reset pulse the counter is held at zero, and it starts again once the pulse ends.

The counter width defaults to 20 bits. The pulse length is counted in clock cycles and defaults to 5.

Top module: `wdt_runaway_guard`

## Requirements
- R1: After `rstN` is released, `intRst` is 0 and the counter is 0. Counting starts on the first clock edge without any enable, so with no other activity the first pulse rises on the 2^CNT_W-th edge after release.
- R2: A pulse starts only when the counter advances out of its all-ones value. That takes 2^CNT_W advancing cycles counted from zero.
- R3: Each pulse keeps `intRst` at 1 for exactly PULSE_LEN (default 5) consecutive cycles.
- R4: A cycle with `wrEn`=1 and `wrClrBit`=0 sets the counter to zero at that edge. The next timeout is then 2^CNT_W edges later.
- R5: The counter is held at zero while `intRst` is 1 and resumes afterwards. With no clears, successive pulses start 2^CNT_W+PULSE_LEN cycles apart.
- R6: A write with `wrClrBit`=1 leaves the counter unchanged. `clrBitRd` always reads 1.
- R7: While `oscStopped` is 1 the counter is zero at every edge. Its timeout restarts when `oscStopped` falls.
- R8: Entering sleep, timebase-timer or watch mode clears the counter. While the mode input stays 1 the counter stays zero.
- R9: While `stopMode` is 1 the counter neither advances nor clears, and no pulse starts. The timeout is delayed by the number of frozen edges.
- R10: If a clear write falls in the same cycle as the terminal count, the clear wins. No pulse is issued and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, which is also the count clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| wrEn | input | 1 | Write strobe for the control register |
| wrClrBit | input | 1 | Value written to the clear bit (0 clears) |
| oscStopped | input | 1 | High while the main oscillator is stopped |
| sleepMode | input | 1 | High while in sleep mode |
| timebaseMode | input | 1 | High while in timebase-timer mode |
| watchMode | input | 1 | High while in watch mode |
| stopMode | input | 1 | High while the processor is halted in stop mode |
| clrBitRd | output | 1 | Read-back value of the clear bit, always 1 |
| intRst | output | 1 | Internal reset pulse, active high |

## Verification
Two functions can fall in the same cycle. The software clear can coincide with the terminal count, and a stop-mode freeze can coincide with the terminal count. The bench counts 2^CNT_W-1 edges from a known clear and drives the clear write into exactly the cycle in which the counter holds all ones. It then checks that `intRst` stays low and that the next pulse arrives a full period after that write. For the freeze, stop mode is held across the moment the timeout would have fallen, and the bench expects the pulse late by exactly the number of frozen edges.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clear;  // force counter to zero (highest priority)
    logic hold;   // keep counter value
  } cnt_cmd_t;

  typedef enum logic [0:0] {
    PS_IDLE = 1'b0,
    PS_FIRE = 1'b1
  } pulse_state_t;

endpackage

// File: rtl/wdt_guard_count.sv
module wdt_guard_count
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cmd,
  output logic [CNT_W-1:0] cntVal,
  output logic             atTerm
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    if (cmd.clear)     cntNext = CNT_ZERO;
    else if (cmd.hold) cntNext = cntQ;
    else               cntNext = cntQ + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= CNT_ZERO;
    else       cntQ <= cntNext;
  end

  assign cntVal = cntQ;
  assign atTerm = &cntQ;

endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int PULSE_LEN = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     wrClrBit,
  input  logic     oscStopped,
  input  logic     sleepMode,
  input  logic     timebaseMode,
  input  logic     watchMode,
  input  logic     stopMode,
  input  logic     atTerm,
  output cnt_cmd_t cmd,
  output logic     intRst
);

  localparam int LEFT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [LEFT_W-1:0] LEFT_LOAD = LEFT_W'(PULSE_LEN - 1);
  localparam logic [LEFT_W-1:0] LEFT_ONE  = LEFT_W'(1);

  pulse_state_t    stateQ, stateNext;
  logic [LEFT_W-1:0] leftQ, leftNext;

  logic clrWrite;
  logic lowPowerClr;
  logic clearReq;
  logic holdReq;
  logic fire;
  logic pulseActive;

  assign pulseActive = (stateQ == PS_FIRE);

  // A write of 0 clears; a write of 1 is ignored.
  assign clrWrite = wrEn & ~wrClrBit;

  // Sleep, timebase-timer and watch clear on entry and keep the count at
  // zero for as long as they are held, so the level is used directly.
  assign lowPowerClr = sleepMode | timebaseMode | watchMode;

  assign clearReq = clrWrite | oscStopped | lowPowerClr | pulseActive;
  assign holdReq  = stopMode;

  // The terminal count only fires when the counter would actually advance.
  assign fire = atTerm & ~clearReq & ~holdReq;

  always_comb begin
    cmd.clear = clearReq;
    cmd.hold  = holdReq;
  end

  always_comb begin
    stateNext = stateQ;
    leftNext  = leftQ;
    unique case (stateQ)
      PS_IDLE: begin
        if (fire) begin
          stateNext = PS_FIRE;
          leftNext  = LEFT_LOAD;
        end
      end
      PS_FIRE: begin
        if (leftQ == '0) stateNext = PS_IDLE;
        else             leftNext  = leftQ - LEFT_ONE;
      end
      default: stateNext = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_IDLE;
      leftQ  <= '0;
    end else begin
      stateQ <= stateNext;
      leftQ  <= leftNext;
    end
  end

  assign intRst = pulseActive;

endmodule

// File: rtl/wdt_runaway_guard.sv
module wdt_runaway_guard
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrClrBit,
  input  logic oscStopped,
  input  logic sleepMode,
  input  logic timebaseMode,
  input  logic watchMode,
  input  logic stopMode,
  output logic clrBitRd,
  output logic intRst
);

  cnt_cmd_t         cmd;
  logic [CNT_W-1:0] cntVal;
  logic             atTerm;

  wdt_guard_ctrl #(
    .PULSE_LEN (PULSE_LEN)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrClrBit     (wrClrBit),
    .oscStopped   (oscStopped),
    .sleepMode    (sleepMode),
    .timebaseMode (timebaseMode),
    .watchMode    (watchMode),
    .stopMode     (stopMode),
    .atTerm       (atTerm),
    .cmd          (cmd),
    .intRst       (intRst)
  );

  wdt_guard_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .cntVal (cntVal),
    .atTerm (atTerm)
  );

  // The clear bit has no storage; it always reads as 1.
  assign clrBitRd = 1'b1;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrClrBit,
  input logic             oscStopped,
  input logic             sleepMode,
  input logic             timebaseMode,
  input logic             watchMode,
  input logic             stopMode,
  input logic             intRst,
  input logic [CNT_W-1:0] cntVal
);

  localparam int HW = $clog2(PULSE_LEN + 2);
  localparam logic [HW-1:0] HI_MAX = HW'(PULSE_LEN + 1);

  logic [HW-1:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hiCnt <= '0;
    else if (!intRst)          hiCnt <= '0;
    else if (hiCnt != HI_MAX)  hiCnt <= hiCnt + HW'(1);
  end

  AST_PULSE_FROM_TERM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intRst) |-> ($past(cntVal) == {CNT_W{1'b1}}));  // R2

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intRst) |-> (hiCnt == HW'(PULSE_LEN)));  // R3

  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    !(intRst && hiCnt >= HW'(PULSE_LEN)));  // R3

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrClrBit) |=> (cntVal == '0));  // R4

  AST_ZERO_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    intRst |-> (cntVal == '0));  // R5

  AST_OSC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    oscStopped |=> (cntVal == '0));  // R7

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode || timebaseMode || watchMode) |=> (cntVal == '0));  // R8

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !intRst && !oscStopped && !sleepMode && !timebaseMode &&
     !watchMode && !(wrEn && !wrClrBit)) |=> ($stable(cntVal) && !$rose(intRst)));  // R9

  AST_CLEAR_BEATS_TERM: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == {CNT_W{1'b1}} && wrEn && !wrClrBit) |=> !intRst);  // R10

endmodule

bind wdt_runaway_guard wdt_guard_chk #(
  .CNT_W     (CNT_W),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrClrBit     (wrClrBit),
  .oscStopped   (oscStopped),
  .sleepMode    (sleepMode),
  .timebaseMode (timebaseMode),
  .watchMode    (watchMode),
  .stopMode     (stopMode),
  .intRst       (intRst),
  .cntVal       (cntVal)
);

// File: tb/tb_wdt_runaway_guard.sv
module tb_wdt_runaway_guard;

  localparam int CW     = 6;
  localparam int PERIOD = 1 << CW;
  localparam int PLEN   = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrClrBit = 1'b0;
  logic oscStopped = 1'b0, sleepMode = 1'b0, timebaseMode = 1'b0;
  logic watchMode = 1'b0, stopMode = 1'b0;
  logic clrBitRd, intRst;

  wdt_runaway_guard #(.CNT_W(CW), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClrBit(wrClrBit),
    .oscStopped(oscStopped), .sleepMode(sleepMode), .timebaseMode(timebaseMode),
    .watchMode(watchMode), .stopMode(stopMode), .clrBitRd(clrBitRd), .intRst(intRst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  typedef struct {
    int    start;
    string tag;
  } exp_t;
  exp_t expQ[$];

  task automatic check(bit ok, string tag, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic expectAt(int start, string tag);
    exp_t e;
    e.start = start;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic writeClr(bit val);
    wrEn = 1'b1; wrClrBit = val;
    @(negedge clk);
    wrEn = 1'b0; wrClrBit = 1'b0;
  endtask

  task automatic holdMode(int sel, int n);
    case (sel)
      0: oscStopped   = 1'b1;
      1: sleepMode    = 1'b1;
      2: timebaseMode = 1'b1;
      3: watchMode    = 1'b1;
      default: stopMode = 1'b1;
    endcase
    idle(n);
    oscStopped = 1'b0; sleepMode = 1'b0; timebaseMode = 1'b0;
    watchMode = 1'b0; stopMode = 1'b0;
  endtask

  // Monitor: measures each pulse and pops the matching expectation
  bit prevRst = 1'b0;
  int pStart = 0;
  int pWidth = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (intRst && !prevRst) begin
        pStart = cyc;
        pWidth = 1;
      end else if (intRst) begin
        pWidth++;
      end else if (prevRst) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected pulse start", pStart, -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(pStart == e.start, e.tag, "pulse start cycle", pStart, e.start);
          check(pWidth == PLEN, "R3", "pulse width", pWidth, PLEN);
        end
      end
      prevRst = intRst;
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finishRun();
  end

  initial begin
    int base;
    int relStart;
    idle(3);
    rstN = 1'b1;
    base = cyc;
    // R1: reset state and automatic start
    check(intRst == 1'b0, "R1", "intRst after reset", int'(intRst), 0);
    check(clrBitRd == 1'b1, "R6", "clear bit read-back", int'(clrBitRd), 1);
    expectAt(base + PERIOD, "R1");
    // R5: counter held during pulse, restarts afterwards
    expectAt(base + 2 * PERIOD + PLEN, "R5");
    idle(2 * PERIOD + PLEN + 10);

    // R4: periodic software clears keep it quiet
    writeClr(1'b0);
    for (int i = 0; i < 5; i++) begin
      idle(PERIOD - 20);
      writeClr(1'b0);
    end
    expectAt(cyc + PERIOD, "R4");
    idle(PERIOD + 10);

    // R6: writing 1 has no effect
    writeClr(1'b0);
    base = cyc;
    for (int i = 0; i < 3; i++) begin
      idle(15);
      writeClr(1'b1);
      check(clrBitRd == 1'b1, "R6", "clear bit read-back after write of 1", int'(clrBitRd), 1);
    end
    expectAt(base + PERIOD, "R6");
    idle(base + PERIOD + 10 - cyc);

    // R7: oscillator stop, R8: low-power modes
    for (int sel = 0; sel < 4; sel++) begin
      writeClr(1'b0);
      idle(30);
      holdMode(sel, PERIOD + 40);
      expectAt(cyc + PERIOD, (sel == 0) ? "R7" : "R8");
      idle(PERIOD + 10);
    end

    // R9: stop mode freezes across the would-be terminal count
    writeClr(1'b0);
    base = cyc;
    idle(30);
    holdMode(4, 50);
    expectAt(base + PERIOD + 50, "R9");
    idle(base + PERIOD + 60 - cyc);

    // R10: clear write in the terminal-count cycle wins
    writeClr(1'b0);
    base = cyc;
    idle(PERIOD - 1);
    writeClr(1'b0);
    relStart = cyc;
    check(intRst == 1'b0, "R10", "intRst after colliding clear", int'(intRst), 0);
    idle(PLEN + 2);
    check(expQ.size() == 0 && intRst == 1'b0, "R10", "no pulse after colliding clear",
          int'(intRst), 0);
    expectAt(relStart + PERIOD, "R10");
    idle(relStart + PERIOD + 10 - cyc);

    check(expQ.size() == 0, "R2", "outstanding expected pulses", expQ.size(), 0);
    finishRun();
  end

endmodule